// File: doc/BRIEF.md
# Sampled Port Change Interrupt Detector

This block watches a small input port and raises a single shared interrupt whenever the combined state of the port changes. Each pin can be masked, and each has a polarity bit that decides whether a high or a low level counts as "asserted". All qualified pins are merged with an OR into one "port active" condition. That condition is sampled only on the falling edge of a slow timebase tick, and the tick comes from one of two rates chosen by a select input.

An interrupt is raised when the sampled condition differs from the previous sample. This happens when the first qualified pin becomes asserted, and again when the last asserted pin returns to idle. Changes between those two points raise nothing. The block produces a one-cycle request pulse and a sticky flag, which software clears. It does not record which pin caused the event, so the handler reads the port to find the source. The vector address of this source is provided as a constant output.

Pins and tick inputs are asynchronous. Each passes through a two-stage synchronizer into the system clock domain.

Top module: `port_chg_irq`

## Requirements
- R1: After reset, `irq_pulse_o` and `irq_flag_o` are 0, and the stored sample is "inactive".
- R2: `vector_o` always reads 16'h0014.
- R3: Pin i counts as asserted when `bit_en_i[i]` is 1 and `pin_i[i]` differs from `pol_i[i]`. Polarity 0 means asserted-high and polarity 1 means asserted-low. A pin whose enable is 0 never contributes.
- R4: If the stored sample is inactive and at least one pin is asserted at a sampling edge, a request is raised.
- R5: If the stored sample is active, a request is raised only at the sampling edge where no pin is asserted. Edges at which some pins are still asserted raise nothing.
- R6: Sampling happens only on a falling edge of the selected tick. `rate_sel_i`=0 selects `tick_slow_i` and `rate_sel_i`=1 selects `tick_fast_i`. Edges on the unselected tick, and pin changes between edges, have no effect.
- R7: `irq_pulse_o` is high for exactly one clock cycle. It goes high on the third rising clock edge after the selected tick goes low, provided the pins were stable for at least three cycles before that.
- R8: `irq_flag_o` is set together with the pulse and stays set until `flag_clr_i` is seen high at a clock edge. If a set and a clear happen in the same cycle, the set wins.
- R9: While `master_en_i` is 0, no pulse is produced and the flag is not set, but the stored sample still tracks the port. Enabling the interrupt later therefore raises nothing for a change that has already been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | W | Asynchronous port pins |
| bit_en_i | input | W | Per-pin interrupt enable |
| pol_i | input | W | Per-pin polarity (1 = asserted-low) |
| master_en_i | input | 1 | Enable for the whole source |
| rate_sel_i | input | 1 | Sampling tick select (0 slow, 1 fast) |
| tick_slow_i | input | 1 | Slow timebase tick |
| tick_fast_i | input | 1 | Fast timebase tick |
| flag_clr_i | input | 1 | Clears the request flag |
| irq_pulse_o | output | 1 | One-cycle request pulse |
| irq_flag_o | output | 1 | Sticky request flag |
| vector_o | output | 16 | Constant vector address |

## Verification
The bench walks the port through three kinds of change:
- An idle port gaining a first asserted pin. This separates the rising case from no change.
- A port with several asserted pins that drop away one at a time. Only the final drop may interrupt, which separates a toggle detector from a per-pin change detector.
- Polarity and enable patterns in which raw pin levels and qualified levels disagree. These show that the masking and the XOR are applied before the OR.

Two further sequences check when sampling happens: ticks on the unselected rate, and pin changes made without any tick. A final sequence toggles the master enable to check that a change sampled while disabled is not reported later.

// File: rtl/port_chg_irq.sv
module port_chg_irq #(
  parameter int          W    = 4,
  parameter int          SYNC = 2,
  parameter logic [15:0] VEC  = 16'h0014
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] bit_en_i,
  input  logic [W-1:0] pol_i,
  input  logic         master_en_i,
  input  logic         rate_sel_i,
  input  logic         tick_slow_i,
  input  logic         tick_fast_i,
  input  logic         flag_clr_i,
  output logic         irq_pulse_o,
  output logic         irq_flag_o,
  output logic [15:0]  vector_o
);

  logic [SYNC-1:0][W-1:0] pin_sync;
  logic [SYNC-1:0]        slow_sync, fast_sync;
  logic                   slow_d, fast_d;
  logic                   samp_q;

  wire [W-1:0] pin_s     = pin_sync[SYNC-1];
  wire         slow_s    = slow_sync[SYNC-1];
  wire         fast_s    = fast_sync[SYNC-1];
  wire         fall_slow = slow_d & ~slow_s;
  wire         fall_fast = fast_d & ~fast_s;
  wire         sample_en = rate_sel_i ? fall_fast : fall_slow;
  wire         active    = |(bit_en_i & (pin_s ^ pol_i));
  wire         set_ev    = sample_en & master_en_i & (active ^ samp_q);

  assign vector_o = VEC;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_sync  <= '0;
      slow_sync <= '0;
      fast_sync <= '0;
      slow_d    <= 1'b0;
      fast_d    <= 1'b0;
    end else begin
      pin_sync  <= {pin_sync[SYNC-2:0], pin_i};
      slow_sync <= {slow_sync[SYNC-2:0], tick_slow_i};
      fast_sync <= {fast_sync[SYNC-2:0], tick_fast_i};
      slow_d    <= slow_s;
      fast_d    <= fast_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      samp_q      <= 1'b0;
      irq_pulse_o <= 1'b0;
      irq_flag_o  <= 1'b0;
    end else begin
      if (sample_en) samp_q <= active;
      irq_pulse_o <= set_ev;
      irq_flag_o  <= set_ev | (irq_flag_o & ~flag_clr_i);
    end

endmodule

module port_chg_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en_i,
  input logic flag_clr_i,
  input logic irq_pulse_o,
  input logic irq_flag_o
);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |=> !irq_pulse_o);

  // R8
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> irq_flag_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_o) |-> irq_pulse_o);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag_o) |-> $past(flag_clr_i));

  // R9
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> $past(master_en_i));

endmodule

bind port_chg_irq port_chg_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i), .flag_clr_i(flag_clr_i),
  .irq_pulse_o(irq_pulse_o), .irq_flag_o(irq_flag_o)
);

// File: tb/test_port_chg_irq.sv
module test_port_chg_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0, en = '0, pol = '0;
  logic       men = 1'b0, rsel = 1'b0, tslow = 1'b0, tfast = 1'b0, clr = 1'b0;
  logic       pulse, flag;
  logic [15:0] vec;
  int errors = 0, checks = 0;
  logic exp_flag = 1'b0;

  always #2.5 clk = ~clk;

  port_chg_irq i_port_chg_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bit_en_i(en), .pol_i(pol),
    .master_en_i(men), .rate_sel_i(rsel), .tick_slow_i(tslow), .tick_fast_i(tfast),
    .flag_clr_i(clr), .irq_pulse_o(pulse), .irq_flag_o(flag), .vector_o(vec));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] v);
    pin = v;
    wait_n(4);
  endtask

  // one falling edge on the chosen tick; checks pulse timing and flag
  task automatic tick(input logic fast, input logic exp_p, input logic do_clr, input string tag);
    if (fast) tfast = 1'b1; else tslow = 1'b1;
    wait_n(3);
    if (fast) tfast = 1'b0; else tslow = 1'b0;
    wait_n(2);
    if (do_clr) clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
    chk({tag, " pulse"}, pulse, exp_p);
    if (exp_p) exp_flag = 1'b1; else if (do_clr) exp_flag = 1'b0;
    chk({tag, " flag"}, flag, exp_flag);
    wait_n(1);
    chk({tag, " pulse width"}, pulse, 0);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
    exp_flag = 1'b0;
    chk("R8 clear", flag, 0);
  endtask

  task automatic t_reset();
    chk("R1 pulse reset", pulse, 0);
    chk("R1 flag reset", flag, 0);
    chk("R2 vector", vec, 16'h0014);
  endtask

  task automatic t_first_active();
    en = 4'b1111; pol = 4'b0000; men = 1'b1; rsel = 1'b0;
    tick(1'b0, 1'b0, 1'b0, "R1 idle sample");
    set_pins(4'b0100);
    wait_n(10);
    chk("R6 no edge no pulse", pulse, 0);
    chk("R6 no edge no flag", flag, 0);
    tick(1'b0, 1'b1, 1'b0, "R4 R7 first asserted");
    clear_flag();
  endtask

  task automatic t_last_inactive();
    set_pins(4'b0110);
    tick(1'b0, 1'b0, 1'b0, "R5 more asserted");
    set_pins(4'b0010);
    tick(1'b0, 1'b0, 1'b0, "R5 one dropped");
    set_pins(4'b0000);
    tick(1'b0, 1'b1, 1'b0, "R5 last dropped");
  endtask

  task automatic t_select();
    rsel = 1'b1;
    set_pins(4'b0001);
    tick(1'b0, 1'b0, 1'b0, "R6 unselected slow");
    tick(1'b1, 1'b1, 1'b0, "R6 selected fast");
  endtask

  task automatic t_polarity();
    pol = 4'b0011;
    set_pins(4'b0011);
    tick(1'b1, 1'b1, 1'b0, "R3 polarity idle");
    set_pins(4'b0001);
    tick(1'b1, 1'b1, 1'b0, "R3 asserted-low pin");
  endtask

  task automatic t_disable();
    en = 4'b1101;
    wait_n(2);
    tick(1'b1, 1'b1, 1'b0, "R3 masked pin removed");
    set_pins(4'b0011);
    tick(1'b1, 1'b0, 1'b0, "R3 masked pin ignored");
  endtask

  task automatic t_master();
    clear_flag();
    men = 1'b0;
    set_pins(4'b0111);
    tick(1'b1, 1'b0, 1'b0, "R9 disabled change");
    men = 1'b1;
    tick(1'b1, 1'b0, 1'b0, "R9 no late trigger");
  endtask

  task automatic t_set_wins();
    set_pins(4'b0011);
    tick(1'b1, 1'b1, 1'b1, "R8 set beats clear");
    clear_flag();
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_first_active();
    t_last_inactive();
    t_select();
    t_polarity();
    t_disable();
    t_master();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule